// File: doc/BRIEF.md
# Suspendable Column Burst Sequencer

This block models the column-burst logic of a synchronous DRAM device. It accepts a command, a column address, a burst-length selection, a clock-enable input, a byte-mask input and write data on every rising clock edge. From these it produces an internal clock enable, the column touched by the current beat, a write strobe into a small on-block storage array, and registered read data with an output enable. A read or write burst walks the columns of an aligned block, wrapping at the block edge, and ends on its own after the programmed number of beats.

The clock-enable input controls suspend. It is registered on every edge. When that registered value is low and a burst is in progress, the next internal edge is suspended. The state machine, the column counter, the storage and the read output all keep their values, and the command and data presented at that edge are discarded. A high sample ends the suspension, and work resumes on the edge that follows. A low sample taken while no burst is running suspends nothing.

The sequencer has three states. `ST_IDLE` waits for a command. `ST_WRITE` and `ST_READ` hold the remaining beats of a burst longer than one. The transitions are: `ST_IDLE -> ST_WRITE` on a write command with length above one; `ST_IDLE -> ST_READ` on a read command with length above one; `ST_WRITE -> ST_IDLE` and `ST_READ -> ST_IDLE` on the live edge that carries the last beat. Every other live edge stays in the same state. A suspended edge never moves the state.

Top module: `sdram_burst_susp`

## Requirements
- R1: While reset is asserted and after it is released, `rd_oe` is 0, `rd_data` is 0, the machine is idle and `int_clk_en` is 1.
- R2: After an edge that samples `cke` low, if a burst is still in progress at the next edge, `int_clk_en` is 0 for that next cycle. An edge that samples `cke` high makes the following edge live.
- R3: A low `cke` sample taken while idle suspends nothing. A command on the next edge is decoded normally.
- R4: On a suspended edge, `cmd`, `col_addr` and `wdata` are ignored. Nothing is written and the burst column does not advance.
- R5: During a suspended edge, `rd_data` and `rd_oe` keep their values.
- R6: `len_sel` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. The value is captured with the command.
- R7: Beat k of a burst (counting from 0) uses column `(n & ~(L-1)) | ((n+k) & (L-1))`, where n is the start column and L is the length.
- R8: A live write beat with `dqm` high writes nothing, but the column still advances. With `dqm` low, `wr_strobe` is 1 and `wdata` is stored at `burst_col`.
- R9: A burst ends after exactly L live beats. Commands presented while a burst is in progress are ignored.
- R10: Each live read beat loads the addressed word into `rd_data` at that edge and sets `rd_oe`. The first live edge after the last read beat clears `rd_oe`, unless that edge starts a new read.
- R11: Command encoding is 00 no-op, 01 write and 10 read. The value 11 acts as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low reset |
| cke | input | 1 | Clock-enable input, sampled each edge |
| cmd | input | 2 | Command (00 no-op, 01 write, 10 read, 11 no-op) |
| col_addr | input | COL_W | Start column for a command |
| len_sel | input | 2 | Burst length select (1, 2, 4, 8) |
| dqm | input | 1 | Write mask for the current beat |
| wdata | input | DW | Write data for the current beat |
| int_clk_en | output | 1 | Internal clock enable (1 = live edge) |
| burst_col | output | COL_W | Column used by the beat at the coming edge |
| wr_strobe | output | 1 | Storage write at the coming edge |
| rd_data | output | DW | Registered read data |
| rd_oe | output | 1 | Read output enable |

## Verification
The bench builds the block with its defaults: `COL_W = 4` and `DW = 16`. With 16 columns, an 8-beat burst spans half of the storage and wraps at both aligned blocks, and random start columns reach every wrap point for every length. The small array also lets a final pair of 8-beat reads return every stored word, so every masked write, suspended write and ignored command is checked against the model's contents.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } burst_state_t;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } burst_op_t;

    localparam int LEN_W = 3;

    // beats minus one for each length selection
    function automatic logic [LEN_W-1:0] len_mask(input logic [1:0] sel);
        logic [LEN_W-1:0] m;
        unique case (sel)
            2'd0:    m = 3'd0;
            2'd1:    m = 3'd1;
            2'd2:    m = 3'd3;
            default: m = 3'd7;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/burst_cke_gate.sv
module burst_cke_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic burst_idle,
    output logic clk_en
);
    logic cke_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_q <= 1'b1;
        end else begin
            cke_q <= cke;
        end
    end

    assign clk_en = cke_q | burst_idle;

    assert_cke_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (burst_idle || !clk_en));

    assert_cke_resume_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> clk_en);

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
#(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  burst_op_t        op,
    input  logic [COL_W-1:0] col,
    input  logic [1:0]       len_sel,
    input  logic             dqm,
    output logic             idle,
    output logic [COL_W-1:0] beat_col,
    output logic             wr_en,
    output logic             rd_en,
    output logic             rd_oe
);
    localparam int PAD = COL_W - LEN_W;

    burst_state_t     state_q, state_n;
    logic [COL_W-1:0] col_q, col_n, base_q, base_n;
    logic [LEN_W-1:0] left_q, left_n, mask_q, mask_n;
    logic             oe_q, oe_n;

    logic             start_wr, start_rd;
    logic [LEN_W-1:0] cur_mask;
    logic [COL_W-1:0] wide_mask, col_step;

    assign start_wr  = (state_q == ST_IDLE) && (op == OP_WRITE);
    assign start_rd  = (state_q == ST_IDLE) && (op == OP_READ);
    assign cur_mask  = (state_q == ST_IDLE) ? len_mask(len_sel) : mask_q;
    assign wide_mask = {{PAD{1'b0}}, cur_mask};
    assign beat_col  = (state_q == ST_IDLE) ? col : col_q;
    assign col_step  = (beat_col & ~wide_mask) | ((beat_col + COL_W'(1)) & wide_mask);

    // next-state and datapath
    always_comb begin
        state_n = state_q;
        col_n   = col_q;
        base_n  = base_q;
        left_n  = left_q;
        mask_n  = mask_q;
        oe_n    = start_rd || (state_q == ST_READ);
        unique case (state_q)
            ST_IDLE: begin
                if ((start_wr || start_rd) && (cur_mask != '0)) begin
                    state_n = start_wr ? ST_WRITE : ST_READ;
                    col_n   = col_step;
                    base_n  = col;
                    left_n  = cur_mask;
                    mask_n  = cur_mask;
                end
            end
            ST_WRITE, ST_READ: begin
                col_n  = col_step;
                left_n = left_q - LEN_W'(1);
                if (left_q == LEN_W'(1)) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            base_q  <= '0;
            left_q  <= '0;
            mask_q  <= '0;
            oe_q    <= 1'b0;
        end else if (clk_en) begin
            state_q <= state_n;
            col_q   <= col_n;
            base_q  <= base_n;
            left_q  <= left_n;
            mask_q  <= mask_n;
            oe_q    <= oe_n;
        end
    end

    // outputs
    always_comb begin
        idle  = (state_q == ST_IDLE);
        wr_en = clk_en && !dqm && (start_wr || (state_q == ST_WRITE));
        rd_en = clk_en && (start_rd || (state_q == ST_READ));
        rd_oe = oe_q;
    end

    assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(state_q) && $stable(col_q) && $stable(left_q)));

    assert_wrap_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |->
            ((col_q & ~{{PAD{1'b0}}, mask_q}) == (base_q & ~{{PAD{1'b0}}, mask_q})));

    assert_beats_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> ((left_q != '0) && (left_q <= mask_q)));

    assert_no_oe_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> !oe_q);

endmodule

// File: rtl/burst_store.sv
module burst_store #(
    parameter int COL_W = 4,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             we,
    input  logic             re,
    input  logic [COL_W-1:0] addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_data
);
    localparam int DEPTH = 1 << COL_W;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (re) begin
            rd_data <= mem_q[addr];
        end
    end

    assert_hold_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(rd_data));

    assert_no_frozen_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> !we);

    assert_one_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));

endmodule

// File: rtl/sdram_burst_susp.sv
module sdram_burst_susp
    import burst_pkg::*;
#(
    parameter int COL_W = 4,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic [1:0]       cmd,
    input  logic [COL_W-1:0] col_addr,
    input  logic [1:0]       len_sel,
    input  logic             dqm,
    input  logic [DW-1:0]    wdata,
    output logic             int_clk_en,
    output logic [COL_W-1:0] burst_col,
    output logic             wr_strobe,
    output logic [DW-1:0]    rd_data,
    output logic             rd_oe
);
    logic      idle, rd_en;
    burst_op_t op;

    assign op = burst_op_t'(cmd);

    burst_cke_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .burst_idle (idle),
        .clk_en     (int_clk_en)
    );

    burst_seq #(.COL_W(COL_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (int_clk_en),
        .op       (op),
        .col      (col_addr),
        .len_sel  (len_sel),
        .dqm      (dqm),
        .idle     (idle),
        .beat_col (burst_col),
        .wr_en    (wr_strobe),
        .rd_en    (rd_en),
        .rd_oe    (rd_oe)
    );

    burst_store #(.COL_W(COL_W), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (int_clk_en),
        .we      (wr_strobe),
        .re      (rd_en),
        .addr    (burst_col),
        .wdata   (wdata),
        .rd_data (rd_data)
    );

endmodule

// File: tb/sdram_burst_susp_bench.sv
`timescale 1ns/1ps
module sdram_burst_susp_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic [1:0]  cmd = 2'b00;
    logic [3:0]  col_addr = '0;
    logic [1:0]  len_sel = '0;
    logic        dqm = 1'b0;
    logic [15:0] wdata = '0;
    logic        int_clk_en, wr_strobe, rd_oe;
    logic [3:0]  burst_col;
    logic [15:0] rd_data;

    always #2.5 clk = ~clk;

    sdram_burst_susp u_sdram_burst_susp (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .col_addr(col_addr),
        .len_sel(len_sel), .dqm(dqm), .wdata(wdata), .int_clk_en(int_clk_en),
        .burst_col(burst_col), .wr_strobe(wr_strobe), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference: 0 idle, 1 writing, 2 reading
    int          m_st = 0;
    int          m_left = 0;
    int          m_mask = 0;
    int          m_col = 0;
    bit          m_ckeq = 1;
    bit          m_oe = 0;
    logic [15:0] m_rd = '0;
    logic [15:0] m_mem [16];

    function automatic int nxt(int c, int mask);
        return ((c & ~mask) | ((c + 1) & mask)) & 15;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit c_cke, logic [1:0] c_cmd, logic [3:0] c_col,
                        logic [1:0] c_sel, bit c_dqm, logic [15:0] c_wd);
        bit e_en, e_wr;
        int e_col, bl;
        cke = c_cke; cmd = c_cmd; col_addr = c_col; len_sel = c_sel;
        dqm = c_dqm; wdata = c_wd;
        #1;
        e_en  = m_ckeq || (m_st == 0);
        e_col = (m_st == 0) ? int'(c_col) : m_col;
        e_wr  = e_en && !c_dqm && (((m_st == 0) && (c_cmd == 2'b01)) || (m_st == 1));
        chk("R2 R3 int_clk_en", 32'(int_clk_en), 32'(e_en));
        chk("R6 R7 burst_col", 32'(burst_col), 32'(e_col));
        chk("R4 R8 R11 wr_strobe", 32'(wr_strobe), 32'(e_wr));
        @(posedge clk);
        if (e_en) begin
            if (m_st == 0) begin
                if (c_cmd == 2'b01 || c_cmd == 2'b10) begin
                    bl = 1 << c_sel;
                    if (c_cmd == 2'b01) begin
                        if (!c_dqm) m_mem[c_col] = c_wd;
                    end else begin
                        m_rd = m_mem[c_col];
                    end
                    m_oe = (c_cmd == 2'b10);
                    if (bl > 1) begin
                        m_st   = (c_cmd == 2'b01) ? 1 : 2;
                        m_left = bl - 1;
                        m_mask = bl - 1;
                        m_col  = nxt(int'(c_col), bl - 1);
                    end
                end else begin
                    m_oe = 0;
                end
            end else begin
                if (m_st == 1) begin
                    if (!c_dqm) m_mem[m_col] = c_wd;
                end else begin
                    m_rd = m_mem[m_col];
                end
                m_oe   = (m_st == 2);
                m_left = m_left - 1;
                m_col  = nxt(m_col, m_mask);
                if (m_left == 0) m_st = 0;
            end
        end
        m_ckeq = c_cke;
        @(negedge clk);
        chk("R5 R10 rd_data", 32'(rd_data), 32'(m_rd));
        chk("R9 R10 rd_oe", 32'(rd_oe), 32'(m_oe));
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rd_oe", 32'(rd_oe), 32'd0);
        chk("R1 rd_data", 32'(rd_data), 32'd0);
        chk("R1 int_clk_en", 32'(int_clk_en), 32'd1);
        rst_n = 1'b1;
        step(1, 2'b00, 4'd0, 2'd0, 0, 16'h0);
        chk("R1 int_clk_en after release", 32'(int_clk_en), 32'd1);

        // R2 R4: write burst of 4 from column 6 with a two-edge suspension
        step(1, 2'b01, 4'd6, 2'd2, 0, 16'hA000);
        step(0, 2'b00, 4'd0, 2'd0, 0, 16'hA001);
        step(0, 2'b10, 4'd3, 2'd0, 0, 16'hBAD0);
        step(1, 2'b01, 4'd9, 2'd0, 0, 16'hBAD1);
        step(1, 2'b00, 4'd0, 2'd0, 0, 16'hA002);
        step(1, 2'b00, 4'd0, 2'd0, 1, 16'hA003);
        // R3: low sample while idle, then a read on the next edge
        step(0, 2'b00, 4'd0, 2'd0, 0, 16'h0);
        step(1, 2'b10, 4'd6, 2'd2, 0, 16'h0);
        step(0, 2'b00, 4'd0, 2'd0, 0, 16'h0);
        step(1, 2'b00, 4'd0, 2'd0, 0, 16'h0);
        for (int i = 0; i < 5; i++) step(1, 2'b00, 4'd0, 2'd0, 0, 16'h0);
        // R11: reserved code acts as no-op
        step(1, 2'b11, 4'd2, 2'd3, 0, 16'h5555);
        step(1, 2'b00, 4'd0, 2'd0, 0, 16'h0);

        // random traffic with suspend pulses of varying length
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, 2'($urandom % 4), 4'($urandom % 16),
                 2'($urandom % 4), ($urandom % 5) == 0, 16'($urandom));
        end

        // drain any burst, then read back the whole array (R6 R10)
        for (int i = 0; i < 10; i++) step(1, 2'b00, 4'd0, 2'd0, 0, 16'h0);
        step(1, 2'b10, 4'd0, 2'd3, 0, 16'h0);
        for (int i = 0; i < 7; i++) step(1, 2'b00, 4'd0, 2'd0, 0, 16'h0);
        step(1, 2'b10, 4'd8, 2'd3, 0, 16'h0);
        for (int i = 0; i < 8; i++) step(1, 2'b00, 4'd0, 2'd0, 0, 16'h0);

        done = 1;
        summary();
        $finish;
    end

endmodule